// File: doc/BRIEF.md
# Row-Bypassing Array Multiplier

This block is a purely combinational unsigned multiplier built as an array of ripple-carry adder rows, one row per bit of the multiplier operand. Each row adds the multiplicand, gated by its own multiplier bit, into a running partial sum. The sum then shifts down one bit position on its way to the next row, and the lowest bit of each row's result becomes one product bit.

To save switching power, a row whose multiplier bit is zero is bypassed. Its adder cells have both data inputs forced low, so they see no toggling. Each cell's sum output selects the incoming running-sum bit instead of the adder result. The carry chain has neither a selector on its output nor gating on its input. With both data inputs held at zero, the carries in that row stay at zero anyway, and a gate on the row's final carry forces it to zero. The block also reports which rows currently have their adders enabled, so the amount of bypassing can be observed from outside.

The multiplier has no clock and no reset. It is intended to sit inside a datapath where both operands are stable for a cycle, and the product settles through the array.

Top module: `rbm_array_mult`

## Requirements
- R1: `prod` equals the unsigned product `a_op * b_op` for every one of the 256 operand pairs at the default width of 4.
- R2: `row_live[j]` is 1 exactly when `b_op[j]` is 1; bit j of `row_live` belongs to the adder row of multiplier bit j. A 0 means that row's adders are bypassed.
- R3: When `b_op` is zero, every row is bypassed (`row_live` is 0) and `prod` is 0.
- R4: When `a_op` is zero, `prod` is 0 for any `b_op`, and `row_live` still follows `b_op`.
- R5: A bypassed row passes the running sum unchanged, shifted one place, including the carry from the row above. When `b_op` has a single bit k set, `prod` equals `a_op` shifted left by k.
- R6: When every row is active (`b_op` all ones), the full carry chain is exercised. For example, 15 × 15 gives 225.
- R7: The output depends only on the present operands. Applying the same operand pair again after other pairs gives the same product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | W | Multiplicand, unsigned |
| b_op | input | W | Multiplier, unsigned; bit j drives adder row j |
| prod | output | 2*W | Unsigned product |
| row_live | output | W | Per-row adder enable, 1 = row active, 0 = bypassed |

## Verification
The checker tests on every input change that the product matches an arithmetic multiply. It also tests that the row-enable flags mirror the multiplier bits, and that a zero operand on either side yields a zero product. Some behaviour can only be shown by the bench's chosen scenarios. These are the shift-through of a bypassed row with single-bit multipliers, the full carry ripple with all rows active, and the repeatability of a product after other operands have been applied. The bench also tallies bypassed-row events against the zero bits it drove, to show that bypassing happens exactly on those bits.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    // majority of three bits: full adder carry
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

    // three-input parity: full adder sum
    function automatic logic par3(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

endpackage

// File: rtl/rbm_cell.sv
module rbm_cell
    import rbm_pkg::*;
(
    input  logic en,      // multiplier bit of this row
    input  logic byp,     // incoming running-sum bit (bypass value)
    input  logic addend,  // multiplicand bit
    input  logic cin,     // ripple carry, never gated
    output logic sum,
    output logic cout     // no selector on the carry
);
    logic byp_g;
    logic add_g;
    logic fa_s;

    // both data inputs held low while the row is bypassed
    assign byp_g = byp & en;
    assign add_g = addend & en;

    assign fa_s = par3(byp_g, add_g, cin);
    assign cout = maj3(byp_g, add_g, cin);

    // control-bit selection on the sum only
    assign sum  = en ? fa_s : byp;
endmodule

// File: rtl/rbm_row.sv
module rbm_row #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] run_in,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] run_out,
    output logic         cout,
    output logic         live
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_cell
        rbm_cell cell_i (
            .en     (en),
            .byp    (run_in[k]),
            .addend (mcand[k]),
            .cin    (chain[k]),
            .sum    (run_out[k]),
            .cout   (chain[k+1])
        );
    end

    // final carry forced to zero on a bypassed row
    assign cout = chain[W] & en;
    assign live = en;
endmodule

// File: rtl/rbm_array_mult.sv
module rbm_array_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a_op,
    input  logic [W-1:0]   b_op,
    output logic [2*W-1:0] prod,
    output logic [W-1:0]   row_live
);
    localparam int PW = 2 * W;

    logic [W-1:0] run_in  [W];
    logic [W-1:0] run_out [W];
    logic         row_co  [W];

    for (genvar j = 0; j < W; j++) begin : g_row
        if (j == 0) begin : g_first
            assign run_in[j] = '0;
        end else begin : g_next
            // shift the previous result down, carry enters at the top
            assign run_in[j] = {row_co[j-1], run_out[j-1][W-1:1]};
        end

        rbm_row #(.W(W)) row_i (
            .en      (b_op[j]),
            .run_in  (run_in[j]),
            .mcand   (a_op),
            .run_out (run_out[j]),
            .cout    (row_co[j]),
            .live    (row_live[j])
        );

        if (j < W - 1) begin : g_low
            assign prod[j] = run_out[j][0];
        end
    end

    assign prod[PW-1:W-1] = {row_co[W-1], run_out[W-1]};
endmodule

// File: rtl/rbm_array_mult_chk.sv
module rbm_array_mult_chk #(
    parameter int W = 4
) (
    input logic [W-1:0]   a_op,
    input logic [W-1:0]   b_op,
    input logic [2*W-1:0] prod,
    input logic [W-1:0]   row_live
);
    logic [2*W-1:0] ref_p;
    assign ref_p = {{W{1'b0}}, a_op} * {{W{1'b0}}, b_op};

    always_comb begin
        // R1
        prod_match_chk: assert (prod == ref_p)
            else $error("product mismatch");
        // R2
        row_flag_chk: assert (row_live == b_op)
            else $error("row enable mismatch");
        // R3
        zero_mplier_chk: assert (b_op != '0 || (prod == '0 && row_live == '0))
            else $error("zero multiplier not bypassed");
        // R4
        zero_mcand_chk: assert (a_op != '0 || prod == '0)
            else $error("zero multiplicand nonzero product");
    end
endmodule

bind rbm_array_mult rbm_array_mult_chk #(.W(W)) chk_i (
    .a_op     (a_op),
    .b_op     (b_op),
    .prod     (prod),
    .row_live (row_live)
);

// File: tb/rbm_array_mult_tb_top.sv
module rbm_array_mult_tb_top;
    localparam int W = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0]   a_op = '0;
    logic [W-1:0]   b_op = '0;
    logic [2*W-1:0] prod;
    logic [W-1:0]   row_live;

    int total = 0;
    int bad = 0;
    int zero_bits_driven = 0;
    int bypass_seen = 0;
    bit finished = 1'b0;

    rbm_array_mult #(.W(W)) dut_i (
        .a_op(a_op), .b_op(b_op), .prod(prod), .row_live(row_live)
    );

    function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [2*W-1:0] acc = '0;
        for (int i = 0; i < W; i++)
            if (y[i]) acc = acc + ({{W{1'b0}}, x} << i);
        return acc;
    endfunction

    function automatic int zeros_of(input logic [W-1:0] y);
        int n = 0;
        for (int i = 0; i < W; i++) if (!y[i]) n++;
        return n;
    endfunction

    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        a_op = x;
        b_op = y;
        @(negedge clk);
        zero_bits_driven += zeros_of(y);
        for (int i = 0; i < W; i++) if (!row_live[i]) bypass_seen++;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d)", tag, act, exp, a_op, b_op);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] first_p;
        void'($urandom(32'd4711));

        // R3 initial all-zero operands
        @(negedge clk);
        chk("R3 idle prod", int'(prod), 0);
        chk("R3 idle rows", int'(row_live), 0);

        // R1 R2 exhaustive
        for (int x = 0; x < (1 << W); x++)
            for (int y = 0; y < (1 << W); y++) begin
                drive(W'(x), W'(y));
                chk("R1 product", int'(prod), int'(exp_prod(W'(x), W'(y))));
                chk("R2 row flags", int'(row_live), y);
            end

        // R3 zero multiplier
        drive(4'hF, 4'h0);
        chk("R3 prod", int'(prod), 0);
        chk("R3 rows", int'(row_live), 0);

        // R4 zero multiplicand
        drive(4'h0, 4'hB);
        chk("R4 prod", int'(prod), 0);
        chk("R4 rows", int'(row_live), 11);

        // R5 single active row, others bypassed
        for (int k = 0; k < W; k++) begin
            drive(4'hD, W'(1 << k));
            chk("R5 shift", int'(prod), 13 << k);
        end
        drive(4'hF, 4'h9);
        chk("R5 outer rows", int'(prod), 135);

        // R6 all rows active
        drive(4'hF, 4'hF);
        chk("R6 max", int'(prod), 225);

        // R7 repeatability plus random mix
        drive(4'h7, 4'h6);
        first_p = prod;
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] rx = W'($urandom);
            logic [W-1:0] ry = W'($urandom);
            drive(rx, ry);
            chk("R1 random", int'(prod), int'(exp_prod(rx, ry)));
        end
        drive(4'h7, 4'h6);
        chk("R7 repeat", int'(prod), int'(first_p));
        chk("R7 value", int'(prod), 42);

        // R2 bypass tally
        chk("R2 bypass count", bypass_seen, zero_bits_driven);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule